// File: doc/BRIEF.md
# Block Boundary Synchronizer with Lock

This block sits just after a receive gearbox and finds where each framed block starts. Every accepted input word is exactly one block wide. That is 66 bits when the framing uses 64b/66b (as in 10GBASE-R) and 67 bits for Interlaken-style framing. A static parameter picks the width. The block keeps the previous word and the current word. It reads a candidate block out of their concatenation at a bit offset, and it checks the candidate's two-bit sync header on every word. Each time a header is bad during the hunt, the offset moves by one bit. Once enough good headers in a row have been seen, block lock is declared.

While lock is held, the aligned block is presented on the output with a valid strobe. A bad header produces a one-cycle error pulse. If too many bad headers arrive inside a fixed-length window, lock is dropped and the hunt starts again.

Top module: `block_sync_lock`

## Requirements
- R1: `ILK_MODE=0` sets the block length to 66 bits and `ILK_MODE=1` sets it to 67 bits. The data ports have this width, and both modes follow the same lock rules.
- R2: Bit 0 of `in_data` is the earliest bit received. The candidate block is `{in_data, previous accepted word}[offset +: BLK]`. Its sync header is its two lowest bits [1:0]. The header is valid when those two bits differ (01 or 10) and invalid when they are 00 or 11.
- R3: During the hunt, an invalid judged header clears the good-header count and moves the offset up by exactly one. The offset wraps from BLK-1 to 0.
- R4: Lock rises in the cycle after the `LOCK_GOOD`-th consecutive valid judged header (default 64). With the correct offset at 0 from reset, lock is low after 64 accepted words and high after 65.
- R5: The first accepted word after reset, after a slip, or after a loss of lock is not judged.
- R6: `hdr_err` pulses for one cycle in the cycle after a judged word with an invalid header, and only when lock was held for that word. It is never high when lock was low in the previous cycle.
- R7: While locked, the `BAD_LIMIT`-th invalid header (default 16) inside a window of `ERR_WIN` judged headers (default 64) drops lock in the next cycle, slips the offset, and restarts the hunt. When this error falls on the last header of a window, losing lock takes priority over closing the window.
- R8: A window of `ERR_WIN` judged headers with fewer than `BAD_LIMIT` errors clears the error count, and lock stays high.
- R9: `blk_valid` is high for one cycle after each judged word that was accepted while lock was held. In that cycle `blk_data` carries that word's aligned block, and successive blocks arrive in stream order.
- R10: A synchronous reset clears lock, the counters and the offset, and drives `blk_valid`, `hdr_err` and `blk_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A raw block-wide word is offered this cycle |
| in_data | input | BLK | Raw word from the gearbox, bit 0 earliest |
| blk_data | output | BLK | Aligned block, header in bits [1:0] |
| blk_valid | output | 1 | `blk_data` holds a block judged while locked |
| blk_lock | output | 1 | Block lock held |
| hdr_err | output | 1 | One-cycle pulse for an invalid header while locked |

## Verification
Two events can land on the same judged header: the error that reaches the loss threshold, and the end of the error-counting window. The bench provokes this by sending 47 further good blocks after lock is declared and then 16 bad blocks, so that the sixteenth bad header is the sixty-fourth judged header of the window. It then expects lock to fall together with the final error pulse. A neighbouring case places 15 bad headers at the end of one window and 15 at the start of the next, and lock must survive because the count is cleared at the window boundary.

// File: rtl/block_sync_lock.sv
module block_sync_lock #(
  parameter int ILK_MODE  = 0,
  parameter int LOCK_GOOD = 64,
  parameter int BAD_LIMIT = 16,
  parameter int ERR_WIN   = 64,
  localparam int BLK = (ILK_MODE != 0) ? 67 : 66
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [BLK-1:0] in_data,
  output logic [BLK-1:0] blk_data,
  output logic           blk_valid,
  output logic           blk_lock,
  output logic           hdr_err
);

  localparam int OW = $clog2(BLK);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int WW = $clog2(ERR_WIN + 1);
  localparam int BW = $clog2(BAD_LIMIT + 1);

  logic [BLK-1:0]   prev_q;
  logic [OW-1:0]    off_q;
  logic             skip_q;
  logic [GW-1:0]    good_q;
  logic [WW-1:0]    wcnt_q;
  logic [BW-1:0]    bcnt_q;

  wire [2*BLK-1:0] pair    = {in_data, prev_q};
  wire [BLK-1:0]   win     = pair[off_q +: BLK];
  wire             hdr_ok  = win[0] ^ win[1];
  wire             judge   = in_valid & ~skip_q;
  wire [OW-1:0]    off_nxt = (off_q == OW'(BLK - 1)) ? '0 : off_q + 1'b1;
  wire             lose    = ~hdr_ok & (bcnt_q == BW'(BAD_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      off_q     <= '0;
      skip_q    <= 1'b1;
      good_q    <= '0;
      wcnt_q    <= '0;
      bcnt_q    <= '0;
      blk_lock  <= 1'b0;
      blk_data  <= '0;
      blk_valid <= 1'b0;
      hdr_err   <= 1'b0;
    end else begin
      blk_valid <= 1'b0;
      hdr_err   <= 1'b0;
      if (in_valid) begin
        prev_q <= in_data;
        skip_q <= 1'b0;
      end
      if (judge) begin
        if (!blk_lock) begin
          if (hdr_ok) begin
            if (good_q == GW'(LOCK_GOOD - 1)) begin
              blk_lock <= 1'b1;
              good_q   <= '0;
              wcnt_q   <= '0;
              bcnt_q   <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end else begin
            good_q <= '0;
            off_q  <= off_nxt;
            skip_q <= 1'b1;
          end
        end else begin
          blk_data  <= win;
          blk_valid <= 1'b1;
          hdr_err   <= ~hdr_ok;
          if (lose) begin
            blk_lock <= 1'b0;
            off_q    <= off_nxt;
            skip_q   <= 1'b1;
            good_q   <= '0;
            wcnt_q   <= '0;
            bcnt_q   <= '0;
          end else if (wcnt_q == WW'(ERR_WIN - 1)) begin
            wcnt_q <= '0;
            bcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
            bcnt_q <= bcnt_q + (hdr_ok ? BW'(0) : BW'(1));
          end
        end
      end
    end
  end

  assert_slip_one_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (off_q != $past(off_q)) |->
      (off_q == (($past(off_q) == OW'(BLK - 1)) ? OW'(0) : OW'($past(off_q) + 1'b1))));

  assert_slip_holds_off_R5: assert property (@(posedge clk) disable iff (rst)
    (off_q != $past(off_q)) |-> skip_q);

  assert_lock_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_lock) |-> ($past(good_q) == GW'(LOCK_GOOD - 1)) && $past(hdr_ok));

  assert_err_only_locked_R6: assert property (@(posedge clk) disable iff (rst)
    hdr_err |-> ($past(blk_lock) && blk_valid));

  assert_bad_below_limit_R7: assert property (@(posedge clk) disable iff (rst)
    blk_lock |-> (bcnt_q < BW'(BAD_LIMIT)));

  assert_valid_only_locked_R9: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> $past(blk_lock));

endmodule

// File: tb/block_sync_lock_test.sv
module block_sync_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] STEP = 64'h9E3779B97F4A7C15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [65:0] in6 = '0;
  logic [66:0] in7 = '0;
  logic [65:0] out6;
  logic [66:0] out7;
  logic v6, v7, lk6, lk7, e6, e7;

  always #(CLK_PERIOD/2) clk = ~clk;

  block_sync_lock #(.ILK_MODE(0)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in6),
    .blk_data(out6), .blk_valid(v6), .blk_lock(lk6), .hdr_err(e6));

  block_sync_lock #(.ILK_MODE(1)) uut67 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in7),
    .blk_data(out7), .blk_valid(v7), .blk_lock(lk7), .hdr_err(e7));

  int checks = 0, errors = 0;
  int p_sh = 0;
  logic [63:0] nblk;
  logic [65:0] a6, b6;
  logic [66:0] a7, b7;

  int herr = 0, unl_err = 0, seq6 = 0, seq7 = 0, vc6 = 0, vc7 = 0;
  logic have6 = 0, have7 = 0, lk_prev = 0;
  logic [63:0] last6, last7;

  function automatic logic [1:0] good_hdr(logic [63:0] n);
    return n[0] ? 2'b10 : 2'b01;
  endfunction

  always @(negedge clk) begin
    if (e6) herr++;
    if ((e6 && !lk_prev) || (e7 && !lk7 && !v7)) unl_err++;
    lk_prev = lk6;
    if (v6) begin
      if (have6 && out6[65:2] != last6 + STEP) seq6++;
      last6 = out6[65:2]; have6 = 1; vc6++;
    end
    if (v7) begin
      if (have7 && out7[65:2] != last7 + STEP) seq7++;
      last7 = out7[65:2]; have7 = 1; vc7++;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_block();
    a6 = b6; a7 = b7;
    b6 = {nblk * STEP, good_hdr(nblk)};
    b7 = {1'b0, nblk * STEP, good_hdr(nblk)};
    nblk++;
  endtask

  task automatic send(input bit bad);
    logic [131:0] t6;
    logic [133:0] t7;
    if (bad) begin
      a6[1:0] = nblk[0] ? 2'b11 : 2'b00;
      a7[1:0] = nblk[0] ? 2'b11 : 2'b00;
    end
    t6 = {b6, a6} >> p_sh;
    t7 = {b7, a7} >> p_sh;
    in6 = t6[65:0];
    in7 = t7[66:0];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    next_block();
  endtask

  task automatic do_reset(input int ph);
    rst = 1'b1; in_valid = 1'b0; p_sh = ph;
    repeat (3) @(negedge clk);
    nblk = 0;
    b6 = '0; b7 = '0;
    next_block(); next_block();
    have6 = 0; have7 = 0; herr = 0;
    #1 rst = 1'b0;
  endtask

  task automatic lock_at_zero();
    do_reset(0);
    repeat (65) send(0);
  endtask

  task automatic t_reset();
    do_reset(0);
    check(lk6 == 0, "R10 lock after reset", lk6, 0);
    check(v6 == 0 && e6 == 0, "R10 valid/err after reset", {v6, e6}, 0);
    check(out6 == '0, "R10 data after reset", out6[31:0], 0);
    check(lk7 == 0, "R10 lock67 after reset", lk7, 0);
  endtask

  task automatic t_threshold();
    do_reset(0);
    repeat (64) send(0);
    check(lk6 == 0, "R4 R5 no lock after 64 words", lk6, 0);
    check(lk7 == 0, "R1 R4 no lock67 after 64 words", lk7, 0);
    send(0);
    check(lk6 == 1, "R4 lock after 65 words", lk6, 1);
    check(lk7 == 1, "R1 R4 lock67 after 65 words", lk7, 1);
  endtask

  task automatic t_early_bad();
    do_reset(0);
    repeat (30) send(0);
    send(1);
    repeat (34) send(0);
    check(lk6 == 0, "R3 bad header restarts count", lk6, 0);
    for (int i = 0; i < 3000 && !lk6; i++) send(0);
    check(lk6 == 1, "R3 offset wraps back to 0 and relocks", lk6, 1);
  endtask

  task automatic t_acquire(input int ph);
    do_reset(ph);
    for (int i = 0; i < 3000 && !(lk6 && lk7); i++) send(0);
    check(lk6 && lk7, "R2 R3 lock at shifted phase", {lk6, lk7}, 3);
    seq6 = 0; seq7 = 0; vc6 = 0; vc7 = 0;
    repeat (30) send(0);
    check(seq6 == 0 && out6[1] != out6[0], "R2 R9 aligned blocks in order", seq6, 0);
    check(vc6 == 30, "R9 one valid per locked word", vc6, 30);
    check(seq7 == 0 && vc7 == 30, "R1 R9 67-bit aligned blocks", seq7 + vc7, 30);
  endtask

  task automatic t_hdr_err();
    lock_at_zero();
    repeat (10) send(0);
    send(1);
    check(e6 == 0, "R6 no pulse before judging", e6, 0);
    send(0);
    check(e6 == 1, "R6 pulse after judging bad header", e6, 1);
    send(0);
    check(e6 == 0, "R6 pulse lasts one cycle", e6, 0);
    repeat (10) send(0);
    check(lk6 == 1 && herr == 1, "R6 single error keeps lock", herr, 1);
  endtask

  task automatic t_loss();
    lock_at_zero();
    repeat (47) send(0);
    repeat (16) send(1);
    check(lk6 == 1, "R7 lock held before 16th judged", lk6, 1);
    send(0);
    check(lk6 == 0 && e6 == 1, "R7 loss wins at window end", {lk6, e6}, 1);
    check(herr == 16, "R7 error pulses counted", herr, 16);
  endtask

  task automatic t_window();
    lock_at_zero();
    repeat (48) send(0);
    repeat (30) send(1);
    repeat (10) send(0);
    check(lk6 == 1, "R8 window end clears error count", lk6, 1);
    check(herr == 30, "R8 errors across two windows", herr, 30);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_threshold();
    t_early_bad();
    t_acquire(7);
    t_acquire(65);
    t_hdr_err();
    t_loss();
    t_window();
    check(unl_err == 0, "R6 no error pulse while unlocked", unl_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule